// File: doc/BRIEF.md
# BCD Time and Calendar Counter

This block keeps wall-clock time and a calendar as packed BCD digits: seconds, minutes, hours, a weekday code, day of month, month and a two-digit year. An external prescaler delivers a one-cycle pulse once per second on `sec_tick`. The block then ripples that pulse through its stages, stepping one stage per clock. It stops as soon as a stage does not wrap. Month lengths, including a 29-day February in years divisible by four, are applied automatically. Hours are kept either as 00..23 or as a 12-hour code with a PM flag in bit 5 of the hour field.

A host port reads and writes every digit as its own 4-bit register. Unused high bits of a digit read as zero and are dropped on write. Reads are combinational from `host_addr`. A write takes effect at the clock edge where `host_wr_en` is high. The current digits and a one-cycle wrap pulse per stage are also driven out for use elsewhere on the chip.

The stepping sequencer is a state machine with seven states:
- `ST_IDLE`: waiting for a tick.
- `ST_SEC`, `ST_MIN`, `ST_HOUR`: step seconds, minutes or hours.
- `ST_DATE`: steps the day and the weekday together.
- `ST_MON`, `ST_YEAR`: step month or year.

The transitions are:
- IDLE goes to SEC on a tick.
- Each stage moves to the next one when it wraps and the step was not cancelled.
- Otherwise it returns to IDLE.
- YEAR always returns to IDLE.

Top module: `bcd_calendar_core`

## Requirements
- R1: Seconds and minutes count 00..59 in BCD. Each wraps from 59 to 00, and that wrap steps the next stage.
- R2: With `mode_12h`=0, hours count 00..23 and wrap 23 to 00. The wrap steps the date stage.
- R3: With `mode_12h`=1, the hour byte runs 12 (midnight), 01..11, 32 (noon), 21..31, then back to 12. Bit 5 is the PM flag. Only the 31 to 12 step counts as an hour wrap into the date stage.
- R4: Each date step advances the 3-bit weekday 0..6 and wraps 6 to 0. A written code 7 becomes 0 on the next date step.
- R5: Days run 01 to the month's last day: 31 for months 01, 03, 05, 07, 08, 10 and 12, and for any out-of-range month code; 30 for months 04, 06, 09 and 11. Past the last day, the day returns to 01 and the month steps.
- R6: February ends on day 29 when the BCD year is divisible by four (00, 04, ..., 12, ..., 96). Otherwise it ends on day 28.
- R7: Months run 01..12, wrap to 01 and step the year. Years run 00..99 and wrap 99 to 00.
- R8: The digit register map is 0/1 seconds units/tens, 2/3 minutes, 4/5 hours, 6 weekday, 8/9 day, A/B month, C/D year. Tens registers keep 3, 3, 2, 2 and 1 bits for seconds, minutes, hours, day and month, and the weekday keeps 3 bits. Other bits read 0. Addresses 7, E and F read 0 and ignore writes.
- R9: A tick sampled at edge k steps seconds at edge k+1, and each further stage one edge later. `stage_carry` bit n pulses for one cycle together with the wrapped value of stage n (0 sec, 1 min, 2 hour, 3 date, 4 month, 5 year).
- R10: A tick that arrives while a ripple is in progress is dropped.
- R11: A host write to a register of the stage being stepped in the same cycle wins. That stage's step, its carry pulse and the rest of the ripple are cancelled.
- R12: Out-of-range digit values still advance. A value at or above the stage limit wraps to the stage's floor with a carry. A units nibble of 9 or more, below the limit, clears and steps the tens.
- R13: After reset the time is 00:00:00, weekday 0, day 01, month 01, year 00, and no carry is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sec_tick | input | 1 | One-cycle pulse per elapsed second |
| mode_12h | input | 1 | 1 selects the 12-hour hour code |
| host_wr_en | input | 1 | Write strobe for the addressed digit |
| host_addr | input | 4 | Digit register address |
| host_wdata | input | 4 | Write data |
| host_rdata | output | 4 | Read data of the addressed digit |
| cur_sec | output | 7 | Seconds, BCD |
| cur_min | output | 7 | Minutes, BCD |
| cur_hour | output | 6 | Hours, BCD with PM flag in bit 5 in 12-hour mode |
| cur_wday | output | 3 | Weekday code 0..6 |
| cur_day | output | 6 | Day of month, BCD |
| cur_mon | output | 5 | Month, BCD |
| cur_year | output | 8 | Year, BCD |
| stage_carry | output | 6 | One-cycle wrap pulse per stage |

## Verification
A host write and a ripple step can land on the same stage in the same cycle. To provoke this, the bench raises the write strobe for the seconds-units register one cycle after the tick, exactly when the sequencer sits in its seconds state with 59 loaded. It judges the result by the seconds holding the written digit, the minutes staying put, and no carry pulse appearing. A second overlap, a fresh tick landing while the minutes stage is busy, is judged by the seconds not stepping a second time.

// File: rtl/bcdcal_pkg.sv
package bcdcal_pkg;

    localparam int NIB_W   = 4;
    localparam int ADDR_W  = 4;
    localparam int N_STAGE = 6;

    localparam int SEC_W  = 7;
    localparam int MIN_W  = 7;
    localparam int HOUR_W = 6;
    localparam int WDAY_W = 3;
    localparam int DAY_W  = 6;
    localparam int MON_W  = 5;
    localparam int YEAR_W = 8;

    localparam logic [ADDR_W-1:0] ADR_SEC_U  = 4'h0;
    localparam logic [ADDR_W-1:0] ADR_SEC_T  = 4'h1;
    localparam logic [ADDR_W-1:0] ADR_MIN_U  = 4'h2;
    localparam logic [ADDR_W-1:0] ADR_MIN_T  = 4'h3;
    localparam logic [ADDR_W-1:0] ADR_HOUR_U = 4'h4;
    localparam logic [ADDR_W-1:0] ADR_HOUR_T = 4'h5;
    localparam logic [ADDR_W-1:0] ADR_WDAY   = 4'h6;
    localparam logic [ADDR_W-1:0] ADR_DAY_U  = 4'h8;
    localparam logic [ADDR_W-1:0] ADR_DAY_T  = 4'h9;
    localparam logic [ADDR_W-1:0] ADR_MON_U  = 4'hA;
    localparam logic [ADDR_W-1:0] ADR_MON_T  = 4'hB;
    localparam logic [ADDR_W-1:0] ADR_YEAR_U = 4'hC;
    localparam logic [ADDR_W-1:0] ADR_YEAR_T = 4'hD;

    localparam int STG_SEC  = 0;
    localparam int STG_MIN  = 1;
    localparam int STG_HOUR = 2;
    localparam int STG_DATE = 3;
    localparam int STG_MON  = 4;
    localparam int STG_YEAR = 5;

    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,
        ST_SEC  = 3'd1,
        ST_MIN  = 3'd2,
        ST_HOUR = 3'd3,
        ST_DATE = 3'd4,
        ST_MON  = 3'd5,
        ST_YEAR = 3'd6
    } step_state_e;

    // Stage that owns a given digit register; ST_IDLE for none.
    function automatic step_state_e owner_of(input logic [ADDR_W-1:0] a);
        step_state_e s;
        case (a)
            ADR_SEC_U, ADR_SEC_T:             s = ST_SEC;
            ADR_MIN_U, ADR_MIN_T:             s = ST_MIN;
            ADR_HOUR_U, ADR_HOUR_T:           s = ST_HOUR;
            ADR_WDAY, ADR_DAY_U, ADR_DAY_T:   s = ST_DATE;
            ADR_MON_U, ADR_MON_T:             s = ST_MON;
            ADR_YEAR_U, ADR_YEAR_T:           s = ST_YEAR;
            default:                          s = ST_IDLE;
        endcase
        return s;
    endfunction

endpackage

// File: rtl/bcd_wrap_next.sv
// Next value of a two-digit BCD field with a run-time upper limit.
module bcd_wrap_next #(
    parameter int W     = 8,
    parameter int FLOOR = 0
) (
    input  logic [W-1:0] cur,
    input  logic [W-1:0] limit,
    output logic [W-1:0] nxt,
    output logic         wrap
);
    localparam int TW = W - 4;

    logic [TW-1:0] tens;

    always_comb begin
        tens = cur[W-1:4];
        wrap = (cur >= limit);
        if (wrap) begin
            nxt = W'(FLOOR);
        end else if (cur[3:0] >= 4'd9) begin
            nxt = {tens + TW'(1), 4'h0};
        end else begin
            nxt = {tens, cur[3:0] + 4'd1};
        end
    end
endmodule

// File: rtl/cal_hour_next.sv
// Hour step for both hour codes.
module cal_hour_next
    import bcdcal_pkg::*;
(
    input  logic [HOUR_W-1:0] cur,
    input  logic              mode_12h,
    output logic [HOUR_W-1:0] nxt,
    output logic              wrap
);
    logic       pm;
    logic [4:0] low;

    always_comb begin
        pm   = cur[5];
        low  = cur[4:0];
        nxt  = cur;
        wrap = 1'b0;
        if (!mode_12h) begin
            if (cur >= 6'h23) begin
                nxt  = 6'h00;
                wrap = 1'b1;
            end else if (cur[3:0] >= 4'd9) begin
                nxt = {cur[5:4] + 2'd1, 4'h0};
            end else begin
                nxt = {cur[5:4], cur[3:0] + 4'd1};
            end
        end else begin
            if (low == 5'h11) begin
                nxt  = {~pm, 5'h12};
                wrap = pm;
            end else if (low >= 5'h12) begin
                nxt = {pm, 5'h01};
            end else if (low[3:0] >= 4'd9) begin
                nxt = {pm, 1'b1, 4'h0};
            end else begin
                nxt = {pm, low[4], low[3:0] + 4'd1};
            end
        end
    end
endmodule

// File: rtl/cal_day_limit.sv
// Last day of the current month, BCD.
module cal_day_limit
    import bcdcal_pkg::*;
(
    input  logic [MON_W-1:0]  mon,
    input  logic [YEAR_W-1:0] year,
    output logic [DAY_W-1:0]  last_day
);
    logic [1:0] rem4;
    logic       leap;

    always_comb begin
        // value mod 4 = (2*tens + units) mod 4
        rem4 = {year[4], 1'b0} + year[1:0];
        leap = (rem4 == 2'd0);
        case (mon)
            5'h02:                      last_day = leap ? 6'h29 : 6'h28;
            5'h04, 5'h06, 5'h09, 5'h11: last_day = 6'h30;
            default:                    last_day = 6'h31;
        endcase
    end
endmodule

// File: rtl/cal_step_fsm.sv
// Ripple sequencer: one stage per clock after a tick.
module cal_step_fsm
    import bcdcal_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               tick,
    input  logic               cancel,
    input  logic [N_STAGE-1:0] stage_wrap,
    output step_state_e        state,
    output logic [N_STAGE-1:0] stage_carry
);
    step_state_e        state_nxt;
    logic               cur_wrap;
    logic [N_STAGE-1:0] cur_onehot;

    always_comb begin
        cur_onehot = '0;
        case (state)
            ST_SEC:  cur_onehot[STG_SEC]  = 1'b1;
            ST_MIN:  cur_onehot[STG_MIN]  = 1'b1;
            ST_HOUR: cur_onehot[STG_HOUR] = 1'b1;
            ST_DATE: cur_onehot[STG_DATE] = 1'b1;
            ST_MON:  cur_onehot[STG_MON]  = 1'b1;
            ST_YEAR: cur_onehot[STG_YEAR] = 1'b1;
            default: cur_onehot = '0;
        endcase
        cur_wrap = |(cur_onehot & stage_wrap) && !cancel;
    end

    always_comb begin
        state_nxt = ST_IDLE;
        unique case (state)
            ST_IDLE: state_nxt = tick     ? ST_SEC  : ST_IDLE;
            ST_SEC:  state_nxt = cur_wrap ? ST_MIN  : ST_IDLE;
            ST_MIN:  state_nxt = cur_wrap ? ST_HOUR : ST_IDLE;
            ST_HOUR: state_nxt = cur_wrap ? ST_DATE : ST_IDLE;
            ST_DATE: state_nxt = cur_wrap ? ST_MON  : ST_IDLE;
            ST_MON:  state_nxt = cur_wrap ? ST_YEAR : ST_IDLE;
            ST_YEAR: state_nxt = ST_IDLE;
            default: state_nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nxt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        stage_carry <= '0;
        else if (cur_wrap) stage_carry <= cur_onehot;
        else               stage_carry <= '0;
    end
endmodule

// File: rtl/bcd_calendar_core.sv
module bcd_calendar_core
    import bcdcal_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               sec_tick,
    input  logic               mode_12h,
    input  logic               host_wr_en,
    input  logic [ADDR_W-1:0]  host_addr,
    input  logic [NIB_W-1:0]   host_wdata,
    output logic [NIB_W-1:0]   host_rdata,
    output logic [SEC_W-1:0]   cur_sec,
    output logic [MIN_W-1:0]   cur_min,
    output logic [HOUR_W-1:0]  cur_hour,
    output logic [WDAY_W-1:0]  cur_wday,
    output logic [DAY_W-1:0]   cur_day,
    output logic [MON_W-1:0]   cur_mon,
    output logic [YEAR_W-1:0]  cur_year,
    output logic [N_STAGE-1:0] stage_carry
);
    step_state_e step_state;
    logic        cancel;
    logic [N_STAGE-1:0] stage_wrap;

    logic [SEC_W-1:0]  sec_q,  sec_nxt;
    logic [MIN_W-1:0]  min_q,  min_nxt;
    logic [HOUR_W-1:0] hour_q, hour_nxt;
    logic [WDAY_W-1:0] wday_q, wday_nxt;
    logic [DAY_W-1:0]  day_q,  day_nxt, day_last;
    logic [MON_W-1:0]  mon_q,  mon_nxt;
    logic [YEAR_W-1:0] year_q, year_nxt;

    function automatic logic wr_hit(input logic en, input logic [ADDR_W-1:0] a,
                                    input logic [ADDR_W-1:0] target);
        return en && (a == target);
    endfunction

    assign cancel = host_wr_en && (step_state != ST_IDLE) &&
                    (owner_of(host_addr) == step_state);

    bcd_wrap_next #(.W(SEC_W), .FLOOR(0)) u_sec (
        .cur(sec_q), .limit(7'h59), .nxt(sec_nxt), .wrap(stage_wrap[STG_SEC]));
    bcd_wrap_next #(.W(MIN_W), .FLOOR(0)) u_min (
        .cur(min_q), .limit(7'h59), .nxt(min_nxt), .wrap(stage_wrap[STG_MIN]));
    cal_hour_next u_hour (
        .cur(hour_q), .mode_12h(mode_12h), .nxt(hour_nxt), .wrap(stage_wrap[STG_HOUR]));
    cal_day_limit u_dlim (
        .mon(mon_q), .year(year_q), .last_day(day_last));
    bcd_wrap_next #(.W(DAY_W), .FLOOR(1)) u_day (
        .cur(day_q), .limit(day_last), .nxt(day_nxt), .wrap(stage_wrap[STG_DATE]));
    bcd_wrap_next #(.W(MON_W), .FLOOR(1)) u_mon (
        .cur(mon_q), .limit(5'h12), .nxt(mon_nxt), .wrap(stage_wrap[STG_MON]));
    bcd_wrap_next #(.W(YEAR_W), .FLOOR(0)) u_year (
        .cur(year_q), .limit(8'h99), .nxt(year_nxt), .wrap(stage_wrap[STG_YEAR]));

    assign wday_nxt = (wday_q >= 3'd6) ? 3'd0 : wday_q + 3'd1;

    cal_step_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .tick(sec_tick), .cancel(cancel),
        .stage_wrap(stage_wrap), .state(step_state), .stage_carry(stage_carry));

    // Digit registers: host write first, then the stage step.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                                      sec_q <= '0;
        else if (wr_hit(host_wr_en, host_addr, ADR_SEC_U)) sec_q[3:0] <= host_wdata;
        else if (wr_hit(host_wr_en, host_addr, ADR_SEC_T)) sec_q[6:4] <= host_wdata[2:0];
        else if (step_state == ST_SEC && !cancel)        sec_q <= sec_nxt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                                      min_q <= '0;
        else if (wr_hit(host_wr_en, host_addr, ADR_MIN_U)) min_q[3:0] <= host_wdata;
        else if (wr_hit(host_wr_en, host_addr, ADR_MIN_T)) min_q[6:4] <= host_wdata[2:0];
        else if (step_state == ST_MIN && !cancel)        min_q <= min_nxt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                                        hour_q <= '0;
        else if (wr_hit(host_wr_en, host_addr, ADR_HOUR_U)) hour_q[3:0] <= host_wdata;
        else if (wr_hit(host_wr_en, host_addr, ADR_HOUR_T)) hour_q[5:4] <= host_wdata[1:0];
        else if (step_state == ST_HOUR && !cancel)         hour_q <= hour_nxt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                                      wday_q <= '0;
        else if (wr_hit(host_wr_en, host_addr, ADR_WDAY)) wday_q <= host_wdata[2:0];
        else if (step_state == ST_DATE && !cancel)       wday_q <= wday_nxt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                                       day_q <= 6'h01;
        else if (wr_hit(host_wr_en, host_addr, ADR_DAY_U)) day_q[3:0] <= host_wdata;
        else if (wr_hit(host_wr_en, host_addr, ADR_DAY_T)) day_q[5:4] <= host_wdata[1:0];
        else if (step_state == ST_DATE && !cancel)        day_q <= day_nxt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                                       mon_q <= 5'h01;
        else if (wr_hit(host_wr_en, host_addr, ADR_MON_U)) mon_q[3:0] <= host_wdata;
        else if (wr_hit(host_wr_en, host_addr, ADR_MON_T)) mon_q[4] <= host_wdata[0];
        else if (step_state == ST_MON && !cancel)         mon_q <= mon_nxt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                                        year_q <= '0;
        else if (wr_hit(host_wr_en, host_addr, ADR_YEAR_U)) year_q[3:0] <= host_wdata;
        else if (wr_hit(host_wr_en, host_addr, ADR_YEAR_T)) year_q[7:4] <= host_wdata;
        else if (step_state == ST_YEAR && !cancel)         year_q <= year_nxt;
    end

    always_comb begin
        case (host_addr)
            ADR_SEC_U:  host_rdata = sec_q[3:0];
            ADR_SEC_T:  host_rdata = {1'b0, sec_q[6:4]};
            ADR_MIN_U:  host_rdata = min_q[3:0];
            ADR_MIN_T:  host_rdata = {1'b0, min_q[6:4]};
            ADR_HOUR_U: host_rdata = hour_q[3:0];
            ADR_HOUR_T: host_rdata = {2'b00, hour_q[5:4]};
            ADR_WDAY:   host_rdata = {1'b0, wday_q};
            ADR_DAY_U:  host_rdata = day_q[3:0];
            ADR_DAY_T:  host_rdata = {2'b00, day_q[5:4]};
            ADR_MON_U:  host_rdata = mon_q[3:0];
            ADR_MON_T:  host_rdata = {3'b000, mon_q[4]};
            ADR_YEAR_U: host_rdata = year_q[3:0];
            ADR_YEAR_T: host_rdata = year_q[7:4];
            default:    host_rdata = '0;
        endcase
    end

    assign cur_sec  = sec_q;
    assign cur_min  = min_q;
    assign cur_hour = hour_q;
    assign cur_wday = wday_q;
    assign cur_day  = day_q;
    assign cur_mon  = mon_q;
    assign cur_year = year_q;
endmodule

// File: rtl/cal_checker.sv
module cal_checker
    import bcdcal_pkg::*;
(
    input logic               clk,
    input logic               rst_n,
    input logic               host_wr_en,
    input logic               mode_12h,
    input step_state_e        step_state,
    input logic [N_STAGE-1:0] stage_carry,
    input logic [SEC_W-1:0]   cur_sec,
    input logic [HOUR_W-1:0]  cur_hour,
    input logic [WDAY_W-1:0]  cur_wday,
    input logic [YEAR_W-1:0]  cur_year
);
    assert_carry_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(stage_carry));

    assert_sec_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (step_state != ST_SEC && !host_wr_en) |=> $stable(cur_sec));

    assert_sec_wrap_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
        stage_carry[STG_SEC] |-> (cur_sec == 7'h00));

    assert_hour_wrap_R3: assert property (@(posedge clk) disable iff (!rst_n)
        stage_carry[STG_HOUR] |-> (cur_hour == ($past(mode_12h) ? 6'h12 : 6'h00)));

    assert_wday_legal_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (step_state == ST_DATE && !host_wr_en) |=> (cur_wday != 3'd7));

    assert_year_wrap_R7: assert property (@(posedge clk) disable iff (!rst_n)
        stage_carry[STG_YEAR] |-> (cur_year == 8'h00));

    assert_busy_drop_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (step_state != ST_IDLE) |=> (step_state != ST_SEC));
endmodule

bind bcd_calendar_core cal_checker u_chk (
    .clk(clk), .rst_n(rst_n), .host_wr_en(host_wr_en), .mode_12h(mode_12h),
    .step_state(step_state), .stage_carry(stage_carry), .cur_sec(cur_sec),
    .cur_hour(cur_hour), .cur_wday(cur_wday), .cur_year(cur_year));

// File: tb/sim_bcd_calendar_core.sv
`timescale 1ns/1ps
module sim_bcd_calendar_core;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sec_tick = 1'b0;
    logic       mode_12h = 1'b0;
    logic       host_wr_en = 1'b0;
    logic [3:0] host_addr = 4'h0;
    logic [3:0] host_wdata = 4'h0;
    logic [3:0] host_rdata;
    logic [6:0] cur_sec, cur_min;
    logic [5:0] cur_hour, cur_day;
    logic [2:0] cur_wday;
    logic [4:0] cur_mon;
    logic [7:0] cur_year;
    logic [5:0] stage_carry;
    logic [5:0] carry_seen = '0;
    int n_checks = 0;
    int n_err = 0;

    always #2 clk = ~clk;

    bcd_calendar_core u0 (
        .clk(clk), .rst_n(rst_n), .sec_tick(sec_tick), .mode_12h(mode_12h),
        .host_wr_en(host_wr_en), .host_addr(host_addr), .host_wdata(host_wdata),
        .host_rdata(host_rdata), .cur_sec(cur_sec), .cur_min(cur_min),
        .cur_hour(cur_hour), .cur_wday(cur_wday), .cur_day(cur_day),
        .cur_mon(cur_mon), .cur_year(cur_year), .stage_carry(stage_carry));

    always @(posedge clk) begin
        #1;
        carry_seen = carry_seen | stage_carry;
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [3:0] d);
        @(negedge clk);
        host_wr_en = 1'b1; host_addr = a; host_wdata = d;
        @(negedge clk);
        host_wr_en = 1'b0;
    endtask

    task automatic set_time(input logic [7:0] h, input logic [7:0] m, input logic [7:0] s);
        wr(4'h0, s[3:0]); wr(4'h1, s[7:4]);
        wr(4'h2, m[3:0]); wr(4'h3, m[7:4]);
        wr(4'h4, h[3:0]); wr(4'h5, h[7:4]);
    endtask

    task automatic set_date(input logic [7:0] d, input logic [7:0] mo,
                            input logic [7:0] y, input logic [3:0] w);
        wr(4'h8, d[3:0]);  wr(4'h9, d[7:4]);
        wr(4'hA, mo[3:0]); wr(4'hB, mo[7:4]);
        wr(4'hC, y[3:0]);  wr(4'hD, y[7:4]);
        wr(4'h6, w);
    endtask

    task automatic tick_settle();
        @(negedge clk); carry_seen = '0; sec_tick = 1'b1;
        @(negedge clk); sec_tick = 1'b0;
        repeat (7) @(negedge clk);
    endtask

    task automatic t_reset();
        chk("R13 sec", cur_sec, 0);   chk("R13 min", cur_min, 0);
        chk("R13 hour", cur_hour, 0); chk("R13 wday", cur_wday, 0);
        chk("R13 day", cur_day, 6'h01); chk("R13 mon", cur_mon, 5'h01);
        chk("R13 year", cur_year, 0); chk("R13 carry", stage_carry, 0);
    endtask

    task automatic t_ripple();
        mode_12h = 1'b0;
        set_time(8'h23, 8'h59, 8'h59); set_date(8'h31, 8'h12, 8'h99, 4'h6);
        @(negedge clk); sec_tick = 1'b1;
        @(negedge clk); sec_tick = 1'b0;
        chk("R9 sec before step", cur_sec, 7'h59);
        @(negedge clk);
        chk("R1 sec wrap", cur_sec, 0); chk("R9 carry sec", stage_carry, 6'b000001);
        chk("R9 min not yet", cur_min, 7'h59);
        @(negedge clk);
        chk("R1 min wrap", cur_min, 0); chk("R9 carry min", stage_carry, 6'b000010);
        @(negedge clk);
        chk("R2 hour wrap", cur_hour, 0); chk("R9 carry hour", stage_carry, 6'b000100);
        @(negedge clk);
        chk("R5 day wrap", cur_day, 6'h01); chk("R4 wday wrap", cur_wday, 0);
        chk("R9 carry date", stage_carry, 6'b001000);
        @(negedge clk);
        chk("R7 mon wrap", cur_mon, 5'h01); chk("R9 carry mon", stage_carry, 6'b010000);
        @(negedge clk);
        chk("R7 year wrap", cur_year, 0); chk("R9 carry year", stage_carry, 6'b100000);
        @(negedge clk);
        chk("R9 carry ends", stage_carry, 0);
    endtask

    task automatic t_units();
        set_time(8'h09, 8'h00, 8'h08);
        tick_settle(); chk("R1 sec step", cur_sec, 7'h09);
        tick_settle(); chk("R1 sec units carry", cur_sec, 7'h10);
        chk("R1 no stage carry", carry_seen, 0);
        set_time(8'h09, 8'h59, 8'h59);
        tick_settle(); chk("R2 hour 09 to 10", cur_hour, 6'h10);
    endtask

    task automatic t_12h();
        mode_12h = 1'b1;
        set_date(8'h15, 8'h06, 8'h20, 4'h2);
        set_time(8'h11, 8'h59, 8'h59);
        tick_settle(); chk("R3 11AM to noon", cur_hour, 6'h32);
        chk("R3 no day step at noon", cur_day, 6'h15);
        set_time(8'h32, 8'h59, 8'h59);
        tick_settle(); chk("R3 noon to 1PM", cur_hour, 6'h21);
        set_time(8'h31, 8'h59, 8'h59);
        tick_settle(); chk("R3 11PM to midnight", cur_hour, 6'h12);
        chk("R3 day step", cur_day, 6'h16); chk("R4 wday step", cur_wday, 3);
        set_time(8'h12, 8'h59, 8'h59);
        tick_settle(); chk("R3 midnight to 1AM", cur_hour, 6'h01);
        mode_12h = 1'b0;
    endtask

    task automatic day_edge(input string req, input logic [7:0] d, input logic [7:0] mo,
                            input logic [7:0] y, input logic [7:0] exp_d,
                            input logic [7:0] exp_mo);
        set_date(d, mo, y, 4'h0);
        set_time(8'h23, 8'h59, 8'h59);
        tick_settle();
        chk(req, {cur_mon, cur_day}, {exp_mo[4:0], exp_d[5:0]});
    endtask

    task automatic t_months();
        day_edge("R5 April 30 ends", 8'h30, 8'h04, 8'h21, 8'h01, 8'h05);
        day_edge("R5 May has 31",    8'h30, 8'h05, 8'h21, 8'h31, 8'h05);
        day_edge("R5 Nov 30 ends",   8'h30, 8'h11, 8'h21, 8'h01, 8'h12);
        day_edge("R6 Feb 28 leap 24", 8'h28, 8'h02, 8'h24, 8'h29, 8'h02);
        day_edge("R6 Feb 29 ends",   8'h29, 8'h02, 8'h24, 8'h01, 8'h03);
        day_edge("R6 Feb 28 plain 23", 8'h28, 8'h02, 8'h23, 8'h01, 8'h03);
        day_edge("R6 leap year 12",  8'h28, 8'h02, 8'h12, 8'h29, 8'h02);
        day_edge("R6 leap year 00",  8'h28, 8'h02, 8'h00, 8'h29, 8'h02);
        day_edge("R6 plain year 10", 8'h28, 8'h02, 8'h10, 8'h01, 8'h03);
        day_edge("R7 month 12 wraps", 8'h31, 8'h12, 8'h41, 8'h01, 8'h01);
        chk("R7 year step", cur_year, 8'h42);
    endtask

    task automatic t_wday7();
        set_date(8'h10, 8'h03, 8'h30, 4'h7);
        set_time(8'h23, 8'h59, 8'h59);
        tick_settle(); chk("R4 code 7 to 0", cur_wday, 0);
        tick_settle(); chk("R4 no step without hour wrap", cur_wday, 0);
    endtask

    task automatic rd(input string req, input logic [3:0] a, input logic [3:0] exp);
        @(negedge clk); host_addr = a;
        #1 chk(req, host_rdata, exp);
    endtask

    task automatic t_regmap();
        set_time(8'h14, 8'h37, 8'h25); set_date(8'h27, 8'h10, 8'h58, 4'h5);
        rd("R8 sec units", 4'h0, 4'h5); rd("R8 sec tens", 4'h1, 4'h2);
        rd("R8 min units", 4'h2, 4'h7); rd("R8 min tens", 4'h3, 4'h3);
        rd("R8 hour units", 4'h4, 4'h4); rd("R8 hour tens", 4'h5, 4'h1);
        rd("R8 wday", 4'h6, 4'h5); rd("R8 day units", 4'h8, 4'h7);
        rd("R8 day tens", 4'h9, 4'h2); rd("R8 mon units", 4'hA, 4'h0);
        rd("R8 mon tens", 4'hB, 4'h1); rd("R8 year units", 4'hC, 4'h8);
        rd("R8 year tens", 4'hD, 4'h5);
        wr(4'h9, 4'hF); rd("R8 day tens masked", 4'h9, 4'h3);
        wr(4'hB, 4'hE); rd("R8 mon tens masked", 4'hB, 4'h0);
        wr(4'h7, 4'hF); rd("R8 addr 7 reads 0", 4'h7, 4'h0);
        wr(4'hE, 4'hF); rd("R8 addr E reads 0", 4'hE, 4'h0);
        rd("R8 addr F reads 0", 4'hF, 4'h0);
        chk("R8 unused writes leave time", {cur_hour, cur_min, cur_sec}, {6'h14, 7'h37, 7'h25});
    endtask

    task automatic t_drop();
        set_time(8'h05, 8'h10, 8'h59);
        @(negedge clk); sec_tick = 1'b1;
        @(negedge clk); sec_tick = 1'b0;
        @(negedge clk); sec_tick = 1'b1;
        @(negedge clk); sec_tick = 1'b0;
        repeat (7) @(negedge clk);
        chk("R10 busy tick dropped sec", cur_sec, 0);
        chk("R10 min once", cur_min, 7'h11);
    endtask

    task automatic t_collide();
        set_time(8'h05, 8'h20, 8'h59);
        @(negedge clk); carry_seen = '0; sec_tick = 1'b1;
        @(negedge clk); sec_tick = 1'b0;
        host_wr_en = 1'b1; host_addr = 4'h0; host_wdata = 4'h3;
        @(negedge clk); host_wr_en = 1'b0;
        repeat (7) @(negedge clk);
        chk("R11 write wins", cur_sec, 7'h53);
        chk("R11 minute untouched", cur_min, 7'h20);
        chk("R11 no carry", carry_seen, 0);
        tick_settle(); chk("R11 next tick normal", cur_sec, 7'h54);
    endtask

    task automatic t_oor();
        set_time(8'h05, 8'h20, 8'h5C);
        tick_settle(); chk("R12 sec 5C wraps", cur_sec, 0);
        chk("R12 wrap carries", cur_min, 7'h21);
        set_time(8'h05, 8'h20, 8'h1C);
        tick_settle(); chk("R12 units C steps tens", cur_sec, 7'h20);
        day_edge("R12 month 15 uses 31 and wraps", 8'h31, 8'h15, 8'h50, 8'h01, 8'h01);
        chk("R12 year after month wrap", cur_year, 8'h51);
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_checks++; n_err++;
        $display("FAIL watchdog: actual hung expected done");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_ripple();
        t_units();
        t_12h();
        t_months();
        t_wday7();
        t_regmap();
        t_drop();
        t_collide();
        t_oor();
        finish_run();
    end
endmodule